// File: doc/BRIEF.md
# EDO Page-Mode DRAM Controller

This block sits between a synchronous host and an asynchronous extended-data-out DRAM. The host presents one word request at a time over a valid/ready handshake: an 18-bit word address, a write flag, two byte enables and 16 bits of write data. The controller turns each request into strobe sequences on the memory side. The upper nine address bits select the row and go out on the shared address pins when the row strobe falls. The lower nine bits select the column and go out on the same pins when a column strobe falls. The low byte enable drives the lower column strobe, which covers data bits 7..0. The high byte enable drives the upper column strobe, which covers bits 15..8.

After an access the row stays active. A later request to the same row therefore costs only a column cycle. The row is closed when a request targets another row, when a refresh is pending, or when the row strobe has been low for close to its permitted maximum. A refresh request triggers a column-before-row refresh cycle. Every timing interval is a parameter counted in clock cycles. Read data is captured one cycle after the column strobe rises. This relies on the memory holding its output until the next column strobe falls.

Top module: `edo_page_ctrl`

## Requirements
- R1: When the row strobe falls, the address pins carry req_addr[17:9]. When a column strobe falls, they carry req_addr[8:0] of the same request.
- R2: Enable bit 0 drives the lower column strobe, which covers data bits 7..0. Enable bit 1 drives the upper strobe, which covers bits 15..8. A byte access pulses only the matching strobe and changes only that lane of memory.
- R3: A request whose row equals the active row is served without a new row-strobe fall.
- R4: A request to a different row closes the active row. The row strobe then stays high for at least T_RP cycles before it falls again with the new row.
- R5: Once the row strobe falls, it stays low for at least T_RAS cycles.
- R6: In an access, the first column strobe falls no sooner than T_RCD cycles after the row strobe falls.
- R7: In an access, each column strobe low pulse lasts at least T_CAS cycles. The strobes stay high for at least T_CP cycles between pulses.
- R8: A write is an early write. When the column strobe falls, write-enable is low, the write data is driven with the drive enable high, and output-enable is high. A write produces no read-data pulse.
- R9: A read produces exactly one rd_valid pulse. rd_data is sampled one cycle after the column strobe rises and equals the stored word on the strobed lanes.
- R10: A refresh request first closes any active row. Both column strobes then go low at least T_CSR cycles before the row strobe falls, with write-enable high. They stay low for at least T_CHR cycles after it. ref_done pulses when the cycle ends. The next access needs a new row activation.
- R11: The row strobe never stays low for more than T_RASMAX cycles, even when the host is idle.
- R12: During and right after reset, all strobes and write-enable are high, the data drive is off, rd_valid is low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge |
| req_addr | input | 18 | Word address, row in the upper half |
| req_we | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables, bit 0 = low byte |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | One-cycle read-data pulse |
| rd_data | output | 16 | Read data |
| ref_req | input | 1 | Refresh request pulse |
| ref_done | output | 1 | Refresh cycle finished |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_lcas_n | output | 1 | Lower column strobe, active low |
| mem_ucas_n | output | 1 | Upper column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_addr | output | 9 | Multiplexed row/column address |
| mem_dq_out | output | 16 | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data from memory |

## Verification
The assertions check the strobe timing on every cycle. They cover the minimum row-low time and the maximum row-low time, the row precharge before each fall, the row-to-column delay, the column precharge, the write-enable and data setup at a write's column fall, and the refresh ordering. Only the bench scenarios can show the rest. They show that data reaches the right lanes and addresses, that a same-row request reuses the open row while a different row forces a new activation, and that read data is taken after the strobe rises. A swept write-then-read pass over a grid of rows and columns shows these results.

// File: rtl/edo_page_ctrl.sv
`timescale 1ns/1ps
module edo_page_ctrl #(
  parameter int ROW_W    = 9,
  parameter int COL_W    = 9,
  parameter int DQ_W     = 16,
  parameter int T_RP     = 7,
  parameter int T_RCD    = 4,
  parameter int T_RAS    = 9,
  parameter int T_CAS    = 2,
  parameter int T_CP     = 2,
  parameter int T_CSR    = 2,
  parameter int T_CHR    = 2,
  parameter int T_RASMAX = 25000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic                   req_we,
  input  logic [1:0]             req_be,
  input  logic [DQ_W-1:0]        req_wdata,
  output logic                   rd_valid,
  output logic [DQ_W-1:0]        rd_data,
  input  logic                   ref_req,
  output logic                   ref_done,
  output logic                   mem_ras_n,
  output logic                   mem_lcas_n,
  output logic                   mem_ucas_n,
  output logic                   mem_we_n,
  output logic                   mem_oe_n,
  output logic [ROW_W-1:0]       mem_addr,
  output logic [DQ_W-1:0]        mem_dq_out,
  output logic                   mem_dq_oe,
  input  logic [DQ_W-1:0]        mem_dq_in
);
  localparam int AW       = ROW_W + COL_W;
  localparam int TW       = $clog2(T_RASMAX + 1) + 1;
  localparam int PAGE_CYC = T_CAS + T_CP + 1;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE, ST_ACT, ST_CAS, ST_CP, ST_OPEN, ST_CLOSE,
    ST_CBR_SET, ST_CBR_HOLD, ST_CBR_RAS
  } state_t;

  state_t           st;
  logic [TW-1:0]    tmr, tras_left, rmax_left;
  logic [ROW_W-1:0] open_row;
  logic [COL_W-1:0] col_q;
  logic             we_q, cap, ref_pend;
  logic [1:0]       be_q;
  logic [DQ_W-1:0]  wd_q;

  logic hit, close_c, take_idle, take_open;
  assign hit       = req_addr[AW-1:COL_W] == open_row;
  assign close_c   = ref_pend || (rmax_left <= TW'(PAGE_CYC)) || (req_valid && !hit);
  assign take_idle = (st == ST_IDLE) && !ref_pend;
  assign take_open = (st == ST_OPEN) && !close_c;
  assign req_ready = take_idle || (take_open && hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      mem_ras_n <= 1'b1; mem_lcas_n <= 1'b1; mem_ucas_n <= 1'b1;
      mem_we_n <= 1'b1; mem_oe_n <= 1'b1; mem_addr <= '0;
      mem_dq_out <= '0; mem_dq_oe <= 1'b0;
      tmr <= '0; tras_left <= '0; rmax_left <= '0;
      open_row <= '0; col_q <= '0; we_q <= 1'b0; be_q <= 2'b00; wd_q <= '0;
      cap <= 1'b0; ref_pend <= 1'b0; ref_done <= 1'b0;
      rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      rd_valid <= 1'b0;
      ref_done <= 1'b0;
      if (ref_req) ref_pend <= 1'b1;
      if (tmr != '0) tmr <= tmr - 1'b1;
      if (!mem_ras_n) begin
        if (tras_left != '0) tras_left <= tras_left - 1'b1;
        if (rmax_left != '0) rmax_left <= rmax_left - 1'b1;
      end
      case (st)
        ST_IDLE: begin
          if (ref_pend) begin
            mem_lcas_n <= 1'b0; mem_ucas_n <= 1'b0; mem_we_n <= 1'b1;
            tmr <= TW'(T_CSR - 1);
            st  <= ST_CBR_SET;
          end else if (req_valid) begin
            open_row  <= req_addr[AW-1:COL_W];
            col_q     <= req_addr[COL_W-1:0];
            we_q      <= req_we; be_q <= req_be; wd_q <= req_wdata;
            mem_addr  <= req_addr[AW-1:COL_W];
            mem_ras_n <= 1'b0;
            tras_left <= TW'(T_RAS - 1);
            rmax_left <= TW'(T_RASMAX - 1);
            tmr       <= TW'(T_RCD - 1);
            st        <= ST_ACT;
          end
        end
        ST_ACT: begin
          if (tmr == '0) begin
            mem_addr   <= ROW_W'(col_q);
            mem_lcas_n <= ~be_q[0]; mem_ucas_n <= ~be_q[1];
            mem_we_n   <= ~we_q; mem_oe_n <= we_q;
            mem_dq_out <= wd_q; mem_dq_oe <= we_q;
            tmr        <= TW'(T_CAS - 1);
            st         <= ST_CAS;
          end
        end
        ST_CAS: begin
          if (tmr == '0) begin
            mem_lcas_n <= 1'b1; mem_ucas_n <= 1'b1;
            mem_we_n <= 1'b1; mem_dq_oe <= 1'b0;
            cap <= !we_q;
            tmr <= TW'(T_CP - 1);
            st  <= ST_CP;
          end
        end
        ST_CP: begin
          if (cap) begin
            rd_data <= mem_dq_in; rd_valid <= 1'b1;
            cap <= 1'b0; mem_oe_n <= 1'b1;
          end
          if (tmr == '0) st <= ST_OPEN;
        end
        ST_OPEN: begin
          if (close_c) st <= ST_CLOSE;
          else if (req_valid) begin
            col_q      <= req_addr[COL_W-1:0];
            we_q       <= req_we; be_q <= req_be; wd_q <= req_wdata;
            mem_addr   <= ROW_W'(req_addr[COL_W-1:0]);
            mem_lcas_n <= ~req_be[0]; mem_ucas_n <= ~req_be[1];
            mem_we_n   <= ~req_we; mem_oe_n <= req_we;
            mem_dq_out <= req_wdata; mem_dq_oe <= req_we;
            tmr        <= TW'(T_CAS - 1);
            st         <= ST_CAS;
          end
        end
        ST_CLOSE: begin
          if (tras_left == '0) begin
            mem_ras_n <= 1'b1;
            tmr <= TW'(T_RP - 1);
            st  <= ST_PRE;
          end
        end
        ST_PRE: if (tmr == '0) st <= ST_IDLE;
        ST_CBR_SET: begin
          if (tmr == '0) begin
            mem_ras_n <= 1'b0;
            tras_left <= TW'(T_RAS - 1);
            rmax_left <= TW'(T_RASMAX - 1);
            ref_pend  <= 1'b0;
            tmr       <= TW'(T_CHR - 1);
            st        <= ST_CBR_HOLD;
          end
        end
        ST_CBR_HOLD: begin
          if (tmr == '0) begin
            mem_lcas_n <= 1'b1; mem_ucas_n <= 1'b1;
            st <= ST_CBR_RAS;
          end
        end
        ST_CBR_RAS: begin
          if (tras_left == '0) begin
            mem_ras_n <= 1'b1;
            ref_done  <= 1'b1;
            tmr <= TW'(T_RP - 1);
            st  <= ST_PRE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  logic          cas_all;
  logic [TW-1:0] ras_lo_cnt, ras_hi_cnt, cas_hi_cnt, cas_lo_cnt;
  assign cas_all = mem_lcas_n & mem_ucas_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_lo_cnt <= '0; cas_lo_cnt <= '0;
      ras_hi_cnt <= '1; cas_hi_cnt <= '1;
    end else begin
      ras_lo_cnt <= mem_ras_n ? '0 : ras_lo_cnt + 1'b1;
      cas_lo_cnt <= cas_all ? '0 : cas_lo_cnt + 1'b1;
      ras_hi_cnt <= !mem_ras_n ? '0 : (ras_hi_cnt == '1 ? ras_hi_cnt : ras_hi_cnt + 1'b1);
      cas_hi_cnt <= !cas_all ? '0 : (cas_hi_cnt == '1 ? cas_hi_cnt : cas_hi_cnt + 1'b1);
    end
  end

  a_r5_ras_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ras_n) |-> ras_lo_cnt >= TW'(T_RAS));
  a_r11_ras_max: assert property (@(posedge clk) disable iff (!rst_n)
    ras_lo_cnt <= TW'(T_RASMAX));
  a_r4_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ras_n) |-> ras_hi_cnt >= TW'(T_RP));
  a_r6_rcd: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_all) && !mem_ras_n) |-> ras_lo_cnt >= TW'(T_RCD));
  a_r7_cas_pre: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_all) |-> cas_hi_cnt >= TW'(T_CP));
  a_r8_early_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_all) && !mem_ras_n && !mem_we_n) |-> (mem_dq_oe && mem_oe_n));
  a_r10_cbr_we: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_ras_n) && !cas_all) |-> mem_we_n);
  a_r10_cbr_setup: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_ras_n) && !cas_all) |-> cas_lo_cnt >= TW'(T_CSR));
endmodule

// File: tb/edo_page_ctrl_tb_top.sv
`timescale 1ns/1ps
module edo_page_ctrl_tb_top;
  localparam int T_RP = 3, T_RCD = 2, T_RAS = 6, T_CAS = 2, T_CP = 2;
  localparam int T_CSR = 2, T_CHR = 2, T_RASMAX = 40;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0, ref_req = 0;
  logic [17:0] req_addr = '0;
  logic [1:0]  req_be = 2'b11;
  logic [15:0] req_wdata = '0, mem_dq_in = '0;
  logic req_ready, rd_valid, ref_done;
  logic [15:0] rd_data, mem_dq_out;
  logic mem_ras_n, mem_lcas_n, mem_ucas_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [8:0] mem_addr;

  always #2 clk = ~clk;

  edo_page_ctrl #(.T_RP(T_RP), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_CAS(T_CAS),
    .T_CP(T_CP), .T_CSR(T_CSR), .T_CHR(T_CHR), .T_RASMAX(T_RASMAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_be(req_be), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .ref_req(ref_req), .ref_done(ref_done),
    .mem_ras_n(mem_ras_n), .mem_lcas_n(mem_lcas_n), .mem_ucas_n(mem_ucas_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  int n_chk = 0, n_err = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model sampled at negedge; each sample is one cycle
  logic [15:0] mem [0:1023];
  logic [8:0]  last_row = '0, last_col = '0;
  bit  last_l, last_u, in_cbr = 0;
  bit  p_ras = 1, p_cas = 1;
  int  ras_lo = 1000, ras_hi = 1000, cas_lo = 1000, cas_hi = 1000;
  int  act_cnt = 0, cbr_cnt = 0, wr_cnt = 0, rd_pulses = 0, done_cnt = 0;

  always @(negedge clk) begin
    bit cas_a;
    logic [9:0] idx;
    cas_a = mem_lcas_n & mem_ucas_n;
    if (rst_n) begin
      if (rd_valid) rd_pulses++;
      if (ref_done) done_cnt++;
      if (p_ras && !mem_ras_n) begin
        chk(ras_hi >= T_RP, "R4 row precharge", ras_hi, T_RP);
        if (!cas_a) begin
          cbr_cnt++; in_cbr = 1;
          chk(mem_we_n == 1'b1, "R10 we high at cbr", mem_we_n, 1);
          chk(cas_lo >= T_CSR, "R10 cas setup", cas_lo, T_CSR);
        end else begin
          act_cnt++; last_row = mem_addr;
        end
      end
      if (!p_ras && mem_ras_n) begin
        chk(ras_lo >= T_RAS, "R5 ras min", ras_lo, T_RAS);
        chk(ras_lo <= T_RASMAX, "R11 ras max", ras_lo, T_RASMAX);
        in_cbr = 0;
      end
      if (p_cas && !cas_a && !mem_ras_n) begin
        chk(ras_lo >= T_RCD, "R6 rcd", ras_lo, T_RCD);
        chk(cas_hi >= T_CP, "R7 cas precharge", cas_hi, T_CP);
        last_col = mem_addr; last_l = !mem_lcas_n; last_u = !mem_ucas_n;
        idx = {last_row[4:0], mem_addr[4:0]};
        if (!mem_we_n) begin
          chk(mem_dq_oe && mem_oe_n, "R8 early write drive", {mem_dq_oe, mem_oe_n}, 3);
          if (last_l) mem[idx][7:0]  = mem_dq_out[7:0];
          if (last_u) mem[idx][15:8] = mem_dq_out[15:8];
          wr_cnt++;
        end else begin
          if (last_l) mem_dq_in[7:0]  = mem[idx][7:0];
          if (last_u) mem_dq_in[15:8] = mem[idx][15:8];
        end
      end
      if (!p_cas && cas_a && !mem_ras_n) begin
        if (in_cbr) chk(ras_lo >= T_CHR, "R10 cas hold", ras_lo, T_CHR);
        else        chk(cas_lo >= T_CAS, "R7 cas width", cas_lo, T_CAS);
      end
    end
    if (mem_ras_n) begin ras_hi = p_ras ? ras_hi + 1 : 1; end
    else           begin ras_lo = p_ras ? 1 : ras_lo + 1; end
    if (cas_a) begin cas_hi = p_cas ? cas_hi + 1 : 1; end
    else       begin cas_lo = p_cas ? 1 : cas_lo + 1; end
    p_ras = mem_ras_n; p_cas = cas_a;
  end

  task automatic xfer(input logic [17:0] a, input bit we, input logic [1:0] be,
                      input logic [15:0] d, output logic [15:0] q);
    int w0;
    w0 = wr_cnt;
    @(negedge clk); #1;
    req_valid = 1; req_addr = a; req_we = we; req_be = be; req_wdata = d;
    #0.5;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 0;
    q = '0;
    if (we) begin
      while (wr_cnt == w0) begin @(negedge clk); #1; end
    end else begin
      @(negedge clk); #1;
      while (!rd_valid) begin @(negedge clk); #1; end
      q = rd_data;
    end
  endtask

  function automatic logic [17:0] mk(input int r, input int c);
    return {9'(r), 9'(c)};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [15:0] q;
    int a0, c0, r0;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk({mem_ras_n, mem_lcas_n, mem_ucas_n, mem_we_n} == 4'hF, "R12 strobes in reset",
        {mem_ras_n, mem_lcas_n, mem_ucas_n, mem_we_n}, 4'hF);
    rst_n = 1;
    @(negedge clk); #1;
    chk({mem_ras_n, mem_lcas_n, mem_ucas_n, mem_we_n, mem_dq_oe, rd_valid} == 6'b111100,
        "R12 idle outputs", {mem_ras_n, mem_lcas_n, mem_ucas_n, mem_we_n, mem_dq_oe, rd_valid}, 6'b111100);
    chk(req_ready == 1'b1, "R12 ready after reset", req_ready, 1);

    // R1/R2/R9 single word
    xfer(mk(3, 5), 1, 2'b11, 16'hBEEF, q);
    chk(last_row == 9'd3 && last_col == 9'd5, "R1 row/col on pins", {last_row, last_col}, {9'd3, 9'd5});
    chk(last_l && last_u, "R2 both strobes for word", {last_u, last_l}, 3);
    xfer(mk(3, 5), 0, 2'b11, 0, q);
    chk(q == 16'hBEEF, "R9 read word", q, 16'hBEEF);

    // R2 byte lanes
    xfer(mk(7, 9), 1, 2'b11, 16'h1111, q);
    xfer(mk(7, 9), 1, 2'b01, 16'hAAAA, q);
    chk(last_l && !last_u, "R2 low lane only", {last_u, last_l}, 1);
    xfer(mk(7, 9), 1, 2'b10, 16'h5555, q);
    chk(!last_l && last_u, "R2 high lane only", {last_u, last_l}, 2);
    xfer(mk(7, 9), 0, 2'b11, 0, q);
    chk(q == 16'h55AA, "R2 merged lanes", q, 16'h55AA);

    // R3 page hit, R4 miss
    xfer(mk(12, 1), 0, 2'b11, 0, q);
    a0 = act_cnt;
    xfer(mk(12, 2), 0, 2'b11, 0, q);
    xfer(mk(12, 3), 1, 2'b11, 16'h0123, q);
    chk(act_cnt == a0, "R3 no activation on hit", act_cnt, a0);
    xfer(mk(13, 3), 0, 2'b11, 0, q);
    chk(act_cnt == a0 + 1, "R4 activation on miss", act_cnt, a0 + 1);
    chk(last_row == 9'd13, "R4 new row on pins", last_row, 13);

    // R11 idle row closes
    repeat (T_RASMAX + 20) @(negedge clk);
    #1;
    chk(mem_ras_n == 1'b1, "R11 idle row closed", mem_ras_n, 1);

    // R10 refresh with row open and from idle
    xfer(mk(20, 4), 0, 2'b11, 0, q);
    c0 = cbr_cnt; r0 = done_cnt; a0 = act_cnt;
    @(negedge clk); ref_req = 1; @(negedge clk); ref_req = 0;
    while (done_cnt == r0) @(negedge clk);
    chk(cbr_cnt == c0 + 1, "R10 one refresh", cbr_cnt, c0 + 1);
    xfer(mk(20, 5), 0, 2'b11, 0, q);
    chk(act_cnt == a0 + 1, "R10 row reopened", act_cnt, a0 + 1);
    repeat (T_RASMAX + 20) @(negedge clk);
    c0 = cbr_cnt;
    ref_req = 1; @(negedge clk); ref_req = 0;
    while (done_cnt == r0 + 1) @(negedge clk);
    chk(cbr_cnt == c0 + 1, "R10 refresh from idle", cbr_cnt, c0 + 1);

    // sweep: write then read a grid of rows and columns
    r0 = rd_pulses;
    for (int r = 0; r < 32; r++)
      for (int c = 0; c < 32; c++)
        xfer(mk(r, c), 1, 2'b11, 16'(r * 977 + c * 31 + 16'h4000), q);
    chk(rd_pulses == r0, "R8 writes give no read pulse", rd_pulses, r0);
    for (int r = 0; r < 32; r++)
      for (int c = 0; c < 32; c++) begin
        xfer(mk(r, c), 0, 2'b11, 0, q);
        chk(q == 16'(r * 977 + c * 31 + 16'h4000), "R9 sweep readback", q,
            16'(r * 977 + c * 31 + 16'h4000));
        chk(last_row == 9'(r) && last_col == 9'(c), "R1 sweep address", {last_row, last_col}, {9'(r), 9'(c)});
      end
    chk(rd_pulses == r0 + 1024, "R9 one pulse per read", rd_pulses, r0 + 1024);

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule